// File: doc/BRIEF.md
# GHASH Key Power Table Generator

This block turns a 128-bit hash subkey into the constant table that a GF(2^128) hashing engine reads when it processes several blocks per step. It first forms a pre-shifted ("twisted") copy of the key. A bit-serial carry-less multiply-and-reduce datapath then derives the second, third and fourth powers of that twisted key. The block writes the results, together with the reduction constant, to a 256-byte register table through a write port, one 128-bit entry per cycle.

Software or a sequencer pulses `start` with the key on `key`. It then waits for the one-cycle `done` pulse. The consuming engine reads each power in three forms: low half only, halves swapped, and high half only. These forms suit a multiplier built from three 64x64 carry-less products. The third and fourth powers are computed side by side in two accumulators, which shortens the run.

Top module: `ghash_keytab`

## Requirements
- R1: The twisted key T is `{key[126:0],1'b0}`, XORed with the constant C when `key[127]` is 1. C is 0xC2 in bits 127:120, 1 in bit 0, and zero in all other bits. T is stored at the key's base offset 0x10.
- R2: The entry at address 0x00 is written as `{64'h0, 64'hC200_0000_0000_0000}`.
- R3: Each power V is stored as three entries at base offsets b, b+0x10 and b+0x20:
  - b holds `{64'h0, V[63:0]}`.
  - b+0x10 holds `{V[63:0], V[127:64]}`.
  - b+0x20 holds `{V[127:64], 64'h0}`.
  - The bases are 0x10 for T, 0x40 for the square, 0x70 for the cube and 0xA0 for the fourth power.
- R4: The product of a and b is defined as a·b·x^-128 mod P, where P = x^128+x^127+x^126+x^121+1 and bit i of a value is the coefficient of x^i. The square stored is the product of T with T.
- R5: The cube stored is the product of T with the square. The fourth power stored is the product of the square with itself.
- R6: A run makes exactly 13 writes, one per cycle, at addresses 0x00, 0x10, ..., 0xC0 in ascending order. `tbl_we` is low at all other times.
- R7: `busy` is high from the cycle after `start` is accepted until the last write. `done` is high for exactly one cycle, the cycle after the last write, and `busy` is low in that cycle.
- R8: A `start` or a change on `key` while `busy` is high has no effect. The run in progress completes with the table of the key that was accepted, and makes no extra writes.
- R9: After reset, `busy`, `done` and `tbl_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a table build with `key` (accepted only when idle) |
| key | input | 128 | Hash subkey |
| busy | output | 1 | Build in progress |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | 8 | Byte address of the table entry being written |
| tbl_wdata | output | 128 | Table entry data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps all 128 single-bit keys. Each such key isolates one shifted bit, and bit 127 alone exercises the conditional reduction inside the twist. The all-zero key, the all-ones key and an arbitrary dense key exercise many carries in the multiply and reduction chains. These results are compared against a reference that forms the full 255-bit carry-less product and then divides out x^128, so an error in a single reduction step or in a half split shows up in a specific entry. A run with a second start and a different key injected mid-build shows that the run in progress is undisturbed.

// File: rtl/ghash_keytab.sv
module ghash_keytab #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] key,
  output logic         busy,
  output logic         tbl_we,
  output logic [7:0]   tbl_addr,
  output logic [W-1:0] tbl_wdata,
  output logic         done
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(W);
  localparam logic [W-1:0] RC = {8'hC2, {(W-9){1'b0}}, 1'b1};
  localparam logic [W-1:0] CONST_ENT = {{HW{1'b0}}, 8'hC2, {(HW-8){1'b0}}};
  localparam int LAST = 12;

  typedef enum logic [1:0] {S_IDLE, S_SQ, S_PAR, S_WR} state_t;
  state_t st;

  logic [W-1:0]  tw, p2, acc_a, acc_b, bsh;
  logic [CW-1:0] cnt;
  logic [W-1:0]  nxt_a, nxt_b, pw;
  logic [1:0]    form;

  function automatic logic [W-1:0] mstep(input logic [W-1:0] acc, input logic [W-1:0] a, input logic b);
    logic [W-1:0] t, u;
    t = b ? (acc ^ a) : acc;
    u = t[0] ? (t ^ RC) : t;
    return {t[0], u[W-1:1]};
  endfunction

  assign nxt_a = mstep(acc_a, tw, bsh[0]);
  assign nxt_b = mstep(acc_b, p2, bsh[0]);
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tw <= '0; p2 <= '0; acc_a <= '0; acc_b <= '0; bsh <= '0;
      cnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tw    <= {key[W-2:0], 1'b0} ^ (key[W-1] ? RC : '0);
          bsh   <= {key[W-2:0], 1'b0} ^ (key[W-1] ? RC : '0);
          acc_a <= '0;
          cnt   <= '0;
          st    <= S_SQ;
        end
        S_SQ: begin
          acc_a <= nxt_a;
          bsh   <= bsh >> 1;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) begin
            p2    <= nxt_a;
            bsh   <= nxt_a;
            acc_a <= '0;
            acc_b <= '0;
            st    <= S_PAR;
          end
        end
        S_PAR: begin
          acc_a <= nxt_a;
          acc_b <= nxt_b;
          bsh   <= bsh >> 1;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= S_WR;
        end
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(LAST)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    pw   = tw;
    form = 2'd0;
    case (cnt[3:0])
      4'd1, 4'd2, 4'd3:    pw = tw;
      4'd4, 4'd5, 4'd6:    pw = p2;
      4'd7, 4'd8, 4'd9:    pw = acc_a;
      4'd10, 4'd11, 4'd12: pw = acc_b;
      default:             pw = tw;
    endcase
    case (cnt[3:0])
      4'd1, 4'd4, 4'd7, 4'd10: form = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd11: form = 2'd1;
      default:                 form = 2'd2;
    endcase
    if (cnt[3:0] == 4'd0)   tbl_wdata = CONST_ENT;
    else if (form == 2'd0)  tbl_wdata = {{HW{1'b0}}, pw[HW-1:0]};
    else if (form == 2'd1)  tbl_wdata = {pw[HW-1:0], pw[W-1:HW]};
    else                    tbl_wdata = {pw[W-1:HW], {HW{1'b0}}};
  end

  assign tbl_we   = (st == S_WR);
  assign tbl_addr = {cnt[3:0], 4'h0};

  a_r6_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n) tbl_we |-> busy);
  a_r6_first_addr: assert property (@(posedge clk) disable iff (!rst_n) $rose(tbl_we) |-> tbl_addr == 8'h00);
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && $past(tbl_we)) |-> tbl_addr == $past(tbl_addr) + 8'h10);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(tbl_we) && $past(tbl_addr) == 8'hC0 && !busy));
  a_r8_key_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tw));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(tbl_we && tbl_addr == 8'hC0)) |=> busy);
endmodule

// File: tb/test_ghash_keytab.sv
module test_ghash_keytab;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] key = '0;
  logic         busy, tbl_we, done;
  logic [7:0]   tbl_addr;
  logic [127:0] tbl_wdata;

  ghash_keytab i_ghash_keytab (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .busy(busy),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wcount = 0;
  bit order_err = 0;
  logic [127:0] tbl [0:15];

  localparam logic [127:0] CC = {8'hC2, 119'b0, 1'b1};

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) if (tbl_we) begin
    if (tbl_addr != 8'(wcount * 16)) order_err = 1;
    tbl[tbl_addr[7:4]] = tbl_wdata;
    wcount++;
  end

  function automatic logic [127:0] gmul(input logic [127:0] a, input logic [127:0] b);
    logic [255:0] prod;
    logic [255:0] poly;
    prod = '0;
    poly = {127'b0, 1'b1, CC};
    for (int i = 0; i < 128; i++) if (b[i]) prod ^= ({128'b0, a} << i);
    for (int i = 0; i < 128; i++) begin
      if (prod[0]) prod ^= poly;
      prod >>= 1;
    end
    return prod[127:0];
  endfunction

  task automatic run(input logic [127:0] k, input bit inject);
    logic [127:0] t, h2, h3, h4, v;
    logic [127:0] e [0:12];
    string tg;
    int n;
    @(negedge clk);
    key = k; start = 1'b1; wcount = 0; order_err = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", {127'b0, busy}, 128'd1);
    n = 0;
    while (done !== 1'b1 && n < 2000) begin
      if (inject && n == 40) begin key = ~k; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R7 done seen", {127'b0, done}, 128'd1);
    t  = {k[126:0], 1'b0} ^ (k[127] ? CC : 128'b0);
    h2 = gmul(t, t);
    h3 = gmul(t, h2);
    h4 = gmul(h2, h2);
    e[0] = {64'h0, 64'hC200_0000_0000_0000};
    for (int p = 0; p < 4; p++) begin
      v = (p == 0) ? t : (p == 1) ? h2 : (p == 2) ? h3 : h4;
      e[1 + 3*p] = {64'h0, v[63:0]};
      e[2 + 3*p] = {v[63:0], v[127:64]};
      e[3 + 3*p] = {v[127:64], 64'h0};
    end
    for (int j = 0; j < 13; j++) begin
      if (inject) tg = "R8 entry";
      else if (j == 0) tg = "R2 const";
      else if (j < 4) tg = "R1 twisted key";
      else if (j < 7) tg = "R4 square";
      else tg = "R5 cube/fourth";
      chk(tbl[j] === e[j], tg, tbl[j], e[j]);
    end
    for (int p = 0; p < 4; p++) begin
      chk(tbl[1+3*p][127:64] == 64'h0 && tbl[3+3*p][63:0] == 64'h0 &&
          tbl[2+3*p] == {tbl[1+3*p][63:0], tbl[3+3*p][127:64]},
          "R3 layout", tbl[2+3*p], {tbl[1+3*p][63:0], tbl[3+3*p][127:64]});
    end
    chk(wcount == 13, inject ? "R8 write count" : "R6 write count", 128'(wcount), 128'd13);
    chk(order_err == 0, "R6 order", {127'b0, order_err}, 128'd0);
    chk(busy === 1'b0, "R7 busy low with done", {127'b0, busy}, 128'd0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", {127'b0, done}, 128'd0);
    chk(tbl_we === 1'b0, "R6 idle no write", {127'b0, tbl_we}, 128'd0);
  endtask

  initial begin
    logic [127:0] x;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && tbl_we === 1'b0, "R9 reset",
        {125'b0, busy, done, tbl_we}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(128'h0, 1'b0);
    run({128{1'b1}}, 1'b0);
    run(128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b0);
    for (int i = 0; i < 128; i++) run(128'd1 << i, 1'b0);
    x = 128'h0123456789abcdeffedcba9876543210;
    for (int i = 0; i < 4; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      run(x, 1'b0);
    end
    run(128'hb83b533708bf535d0aa6e52980d53b78, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule